// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem control byte and the modem status byte of a 16550-style serial port. It synchronises four incoming handshake lines (clear-to-send, data-set-ready, ring, carrier detect) into the clock domain. When a line changes it latches a sticky change flag for that line, and it presents the OR of those flags as a single change indication to the port's interrupt logic.

The control byte drives four handshake outputs: request-to-send, data-terminal-ready and two general-purpose outputs. A loopback bit in the control byte parks all four outputs inactive. In loopback a status read returns the control outputs, remapped onto the line nibble, so that software can test the port without a cable. Software reaches both bytes through a one-bit register select with read and write strobes. Reading the status byte outside loopback clears the change flags.

Top module: `modem_ctl_stat`

## Requirements
- R1: After synchronous reset the control byte reads 0x08 (only the second general-purpose output set), the status byte reads 0xB0, aux2_o is 1, rts_o, dtr_o and aux1_o are 0, and mdm_chg_o is 0.
- R2: A write with reg_sel=0 stores only bits 4..0 of wdata (bit0 DTR, bit1 RTS, bit2 AUX1, bit3 AUX2, bit4 LOOP). A control read returns those bits with bits 7..5 zero.
- R3: With LOOP clear, dtr_o, rts_o, aux1_o and aux2_o equal control bits 0, 1, 2 and 3 from the cycle after the write.
- R4: With LOOP set, all four handshake outputs are 0.
- R5: With LOOP set, a status read returns AUX2 in bit 7, AUX1 in bit 6, DTR in bit 5 and RTS in bit 4, with bits 3..0 zero.
- R6: With LOOP clear, status bits 7..4 show the synchronised lines DCD, RI, DSR and CTS. The new level is visible on the third rising clock edge after an input changes. A change of DCD, DSR or CTS in either direction sets bit 3, 1 or 0 respectively.
- R7: Status bit 2 (ring trailing edge) is set only when RI goes from 1 to 0, never when it rises.
- R8: Change flags are sticky: further changes OR into them, and none clears until a status read.
- R9: A status read outside loopback returns the value held before the read and clears bits 3..0 at the end of the read cycle. A line change that lands on that same edge is kept.
- R10: mdm_chg_o is 1 exactly when any of status bits 3..0 is set.
- R11: A status read in loopback leaves the change flags unchanged.
- R12: A write with reg_sel=1 has no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears change flags) |
| reg_sel | input | 1 | 0 selects control byte, 1 selects status byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected byte |
| cts_i | input | 1 | Clear-to-send line |
| dsr_i | input | 1 | Data-set-ready line |
| ri_i | input | 1 | Ring line |
| dcd_i | input | 1 | Carrier-detect line |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| aux1_o | output | 1 | General-purpose output 1 |
| aux2_o | output | 1 | General-purpose output 2 |
| mdm_chg_o | output | 1 | Any change flag set |

## Verification
All 256 control byte values are written. For each one the bench checks the readback mask, the output pins and the loopback view, which separates the crossed RTS/DTR mapping from a straight one. Every ordered pair of line nibbles (old, new) is applied: 256 transitions that tell the symmetric delta bits apart from the ring bit, which must fire only on a falling edge. Directed sequences cover accumulation across two changes and a change landing on the clearing read edge. They also cover flags surviving a loopback read and a write aimed at the status byte.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int BYTE_W   = 8;
    localparam int LINE_W   = 4;
    localparam int CTL_W    = 5;

    // Control byte bit positions (loopback view depends on these)
    localparam int CB_DTR   = 0;
    localparam int CB_RTS   = 1;
    localparam int CB_AUX1  = 2;
    localparam int CB_AUX2  = 3;
    localparam int CB_LOOP  = 4;

    localparam logic [BYTE_W-1:0] CTL_MASK  = 8'h1F;
    localparam logic [BYTE_W-1:0] CTL_RESET = 8'h08;

    // Handshake line nibble; packed order makes dcd bit 3 and cts bit 0
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

    localparam line_t LINE_RESET = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

    // Change flags produced by one transition old -> now
    function automatic logic [LINE_W-1:0] line_delta(input line_t old_v, input line_t now_v);
        logic [LINE_W-1:0] d;
        d    = old_v ^ now_v;
        d[2] = old_v.ri & ~now_v.ri;   // ring: falling edge only
        return d;
    endfunction

    // Status byte presented while looping back the control outputs
    function automatic logic [BYTE_W-1:0] loop_view(input logic [BYTE_W-1:0] ctl);
        logic [BYTE_W-1:0] v;
        v    = '0;
        v[7] = ctl[CB_AUX2];
        v[6] = ctl[CB_AUX1];
        v[5] = ctl[CB_DTR];
        v[4] = ctl[CB_RTS];
        return v;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int                W      = 4,
    parameter int                STAGES = 2,
    parameter logic [W-1:0]      RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_V;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_V;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_t             line_now,
    input  logic              rd_clr,
    output line_t             line_q,
    output logic [LINE_W-1:0] delta_q
);
    logic [LINE_W-1:0] chg;
    logic [LINE_W-1:0] delta_d;

    always_comb begin
        chg     = line_delta(line_q, line_now);
        delta_d = (rd_clr ? '0 : delta_q) | chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= LINE_RESET;
            delta_q <= '0;
        end else begin
            line_q  <= line_now;
            delta_q <= delta_d;
        end
    end

    AST_RING_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(delta_q[2]) |-> ($past(line_q.ri) && !line_q.ri)); // R7

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && (line_now == line_q)) |=> (delta_q == '0)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!rd_clr && (delta_q != '0)) |=> ((delta_q & $past(delta_q)) == $past(delta_q))); // R8

    AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (line_now.cts != line_q.cts) |=> delta_q[0]); // R6
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctl_q,
    output logic              loop_on,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              aux1_o,
    output logic              aux2_o
);
    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (wr_ctl) ctl_q <= wdata & CTL_MASK;
    end

    always_comb begin
        loop_on = ctl_q[CB_LOOP];
        rts_o   = ctl_q[CB_RTS]  & ~loop_on;
        dtr_o   = ctl_q[CB_DTR]  & ~loop_on;
        aux1_o  = ctl_q[CB_AUX1] & ~loop_on;
        aux2_o  = ctl_q[CB_AUX2] & ~loop_on;
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_ctl |=> (ctl_q == ($past(wdata) & CTL_MASK))); // R2
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              reg_sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              cts_i,
    input  logic              dsr_i,
    input  logic              ri_i,
    input  logic              dcd_i,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              aux1_o,
    output logic              aux2_o,
    output logic              mdm_chg_o
);
    line_t             pins_raw;
    logic [LINE_W-1:0] pins_sync;
    line_t             line_q;
    logic [LINE_W-1:0] delta_q;
    logic [BYTE_W-1:0] ctl_q;
    logic              loop_on;
    logic              rd_clr;

    assign pins_raw = '{dcd: dcd_i, ri: ri_i, dsr: dsr_i, cts: cts_i};

    mdm_sync #(
        .W      (LINE_W),
        .STAGES (SYNC_STAGES),
        .RST_V  (LINE_RESET)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_sync)
    );

    mdm_ctrl ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl  (wr_en && !reg_sel),
        .wdata   (wdata),
        .ctl_q   (ctl_q),
        .loop_on (loop_on),
        .rts_o   (rts_o),
        .dtr_o   (dtr_o),
        .aux1_o  (aux1_o),
        .aux2_o  (aux2_o)
    );

    assign rd_clr = rd_en && reg_sel && !loop_on;

    mdm_delta delta_i (
        .clk      (clk),
        .rst      (rst),
        .line_now (line_t'(pins_sync)),
        .rd_clr   (rd_clr),
        .line_q   (line_q),
        .delta_q  (delta_q)
    );

    always_comb begin
        if (!reg_sel)     rdata = ctl_q;
        else if (loop_on) rdata = loop_view(ctl_q);
        else              rdata = {line_q, delta_q};
    end

    assign mdm_chg_o = |delta_q;

    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        loop_on |-> !(rts_o || dtr_o || aux1_o || aux2_o)); // R4

    AST_LOOP_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_sel && loop_on && mdm_chg_o) |=> mdm_chg_o); // R11
endmodule

// File: tb/modem_ctl_stat_tb_top.sv
`timescale 1ns/1ps
module modem_ctl_stat_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
    logic       rts_o, dtr_o, aux1_o, aux2_o, mdm_chg_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    modem_ctl_stat dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
        .dcd_i(dcd_i), .rts_o(rts_o), .dtr_o(dtr_o), .aux1_o(aux1_o),
        .aux2_o(aux2_o), .mdm_chg_o(mdm_chg_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] v);
        wr_en = 1'b1; reg_sel = sel; wdata = v;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_en = 1'b1; reg_sel = sel;
        #1 v = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [3:0] p);
        dcd_i = p[3]; ri_i = p[2]; dsr_i = p[1]; cts_i = p[0];
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] exp_delta(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] x;
        x = a ^ b;
        return {x[3], a[2] & ~b[2], x[1], x[0]};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [3:0] dl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b0, v); check("R1 ctl", v, 8'h08);
        rd(1'b1, v); check("R1 status", v, 8'hB0);
        check("R1 pins", {4'b0, aux2_o, aux1_o, rts_o, dtr_o}, 8'h08);
        check("R1 chg", {7'b0, mdm_chg_o}, 8'h00);

        // R2 R3 R4 R5 sweep of every control value
        for (int c = 0; c < 256; c++) begin
            logic [7:0] m;
            m = 8'(c) & 8'h1F;
            wr(1'b0, 8'(c));
            rd(1'b0, v); check("R2 ctl mask", v, m);
            if (m[4]) begin
                check("R4 pins quiet", {4'b0, aux2_o, aux1_o, rts_o, dtr_o}, 8'h00);
                rd(1'b1, v);
                check("R5 loop view", v, {m[3], m[2], m[0], m[1], 4'b0});
            end else begin
                check("R3 pins", {4'b0, aux2_o, aux1_o, rts_o, dtr_o}, {4'b0, m[3:0]});
            end
        end
        wr(1'b0, 8'h08);

        // R6 R7 R9 R10 sweep of every line transition
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_pins(4'(a)); settle();
                rd(1'b1, v); rd(1'b1, v);
                check("R9 cleared", v, {4'(a), 4'b0});
                set_pins(4'(b)); settle();
                dl = exp_delta(4'(a), 4'(b));
                check("R10 chg", {7'b0, mdm_chg_o}, {7'b0, |dl});
                rd(1'b1, v);
                check("R6 R7 status", v, {4'(b), dl});
            end
        end

        // R8 accumulation of two changes
        set_pins(4'b1011); settle(); rd(1'b1, v);
        set_pins(4'b1010); settle();
        set_pins(4'b1000); settle();
        rd(1'b1, v); check("R8 accumulate", v, {4'b1000, 4'b0011});

        // R9 change landing on the clearing edge is kept
        set_pins(4'b1100); settle(); rd(1'b1, v); rd(1'b1, v);
        set_pins(4'b1000);
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(1'b1, v); check("R9 pre-value", v, 8'hC0);
        rd(1'b1, v); check("R9 same-edge kept", v, {4'b1000, 4'b0100});

        // R11 loopback read leaves flags
        set_pins(4'b1001); settle();
        wr(1'b0, 8'h1F);
        rd(1'b1, v); check("R11 loop view", v, 8'hF0);
        check("R11 chg kept", {7'b0, mdm_chg_o}, 8'h01);
        wr(1'b0, 8'h08);
        rd(1'b1, v); check("R11 flags kept", v, {4'b1001, 4'b0001});

        // R12 write to status ignored
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check("R12 status write ignored", v, 8'h90);
        rd(1'b0, v); check("R12 ctl untouched", v, 8'h08);

        finish_run();
    end
endmodule